// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock FIFO whose read protocol is fixed at master reset. In standard mode a stored word reaches the output register only after a read request. In fall-through mode the oldest word is moved into the output register without any request, and a read request consumes it. The two status outputs change meaning with the mode. In standard mode they report empty and full. In fall-through mode they report output-ready and input-ready.

Three more flags report occupancy. Half-full compares occupancy against the midpoint of the storage. Almost-empty and almost-full compare occupancy and free space against two offset registers. Both offsets take a common default at master reset, and a select input picks the small default or the large one. Software can overwrite the offsets through a load strobe, which writes them alternately.

Top module: `dual_mode_fifo`

## Requirements
- R1: A word on `wrData` is stored on every rising edge where `wrEn` is high and the FIFO is not full. Words leave in the order they were written.
- R2: `fwftSel` is sampled only while `mstRst` is high. 0 selects standard mode and 1 selects fall-through mode. Changes on `fwftSel` outside reset have no effect.
- R3: In standard mode, a read (`rdEn` high while not empty) loads the oldest word into `rdData` at that edge. `rdData` holds its value in every other cycle.
- R4: In fall-through mode, a word written into an empty FIFO appears on `rdData` with `rdStat` high after the second rising edge following the write. A read while `rdStat` is high consumes that word, and the next stored word, if there is one, replaces it at the same edge.
- R5: In standard mode, `rdStat` is high when the FIFO is empty and `wrStat` is high when it is full. In fall-through mode, `rdStat` is high when the output holds valid data and `wrStat` is high when a write would be accepted.
- R6: `halfFull` is high exactly when occupancy exceeds DEPTH/2, in both modes.
- R7: `almostEmpty` is high exactly when occupancy is less than or equal to the empty-side offset.
- R8: `almostFull` is high exactly when free space (capacity minus occupancy) is less than or equal to the full-side offset.
- R9: At master reset, both offsets become OFF_SMALL (127 by default) when `bigOffSel` is 0, and OFF_LARGE (1023 by default) when `bigOffSel` is 1.
- R10: Each cycle with `offLoad` high writes `offData` into one offset register. The first load after reset goes to the empty-side offset, the next to the full-side offset, and the sequence then alternates.
- R11: A write while full and a read while empty (standard mode) or not output-ready (fall-through mode) are ignored. Stored data, order and flags are unaffected.
- R12: In fall-through mode, occupancy counts the word in the output register, and capacity is DEPTH+1 words. In standard mode, capacity is DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mstRst | input | 1 | Synchronous master reset, active high |
| fwftSel | input | 1 | Mode select sampled in reset: 0 standard, 1 fall-through |
| bigOffSel | input | 1 | Default offset select sampled in reset: 0 small, 1 large |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Output data register |
| rdStat | output | 1 | Empty (standard) or output-ready (fall-through) |
| wrStat | output | 1 | Full (standard) or input-ready (fall-through) |
| halfFull | output | 1 | Occupancy above midpoint |
| almostEmpty | output | 1 | Occupancy at or below the empty-side offset |
| almostFull | output | 1 | Free space at or below the full-side offset |
| offLoad | input | 1 | Offset load strobe |
| offData | input | $clog2(DEPTH) | Offset value to load |

## Verification
The hardest states to reach are the fall-through corners. One is the extra word of capacity at DEPTH+1. Another is the two-edge window in which storage holds a word but the output register is still empty, where the flags must count occupancy correctly. The bench reaches them with a small configuration. For each mode and each default offset choice, it fills the FIFO past capacity and drains it past empty. It then runs a pseudo-random mix of simultaneous reads and writes, reloads the offsets through the alternating load sequence, and sweeps again. An arithmetic model checks every flag and the output word after each cycle.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic memWr;
    logic memRd;
  } strobe_t;
endpackage

// File: rtl/dmfifo_ctrl.sv
module dmfifo_ctrl
  import dmfifo_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int OFF_SMALL = 127,
  parameter int OFF_LARGE = 1023,
  localparam int CW = $clog2(DEPTH + 2),
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          mstRst,
  input  logic          fwftSel,
  input  logic          bigOffSel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          offLoad,
  input  logic [OW-1:0] offData,
  output strobe_t       stb,
  output logic          fwftMode,
  output logic          rdStat,
  output logic          wrStat,
  output logic          halfFull,
  output logic          almostEmpty,
  output logic          almostFull
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
  localparam logic [OW-1:0] SMALL_C = OW'(OFF_SMALL);
  localparam logic [OW-1:0] LARGE_C = OW'(OFF_LARGE);

  logic [CW-1:0] memCnt;
  logic          outValid;
  logic [OW-1:0] aeOff, afOff;
  logic          ldSel;

  logic [CW-1:0] occ, cap, freeSpace;
  logic          memEmpty, isFull, popOut, memRd, memWr;

  always_comb begin
    memEmpty  = (memCnt == '0);
    occ       = memCnt + CW'(outValid);
    cap       = fwftMode ? DEPTH_C + CW'(1) : DEPTH_C;
    freeSpace = cap - occ;
    isFull    = (occ == cap);
    popOut    = fwftMode && rdEn && outValid;
    if (fwftMode) memRd = !memEmpty && (!outValid || popOut);
    else          memRd = rdEn && !memEmpty;
    memWr     = wrEn && !isFull;
    stb.memWr = memWr;
    stb.memRd = memRd;
  end

  always_ff @(posedge clk) begin
    if (mstRst) begin
      fwftMode <= fwftSel;
      memCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      case ({memWr, memRd})
        2'b10:   memCnt <= memCnt + CW'(1);
        2'b01:   memCnt <= memCnt - CW'(1);
        default: memCnt <= memCnt;
      endcase
      if (fwftMode) begin
        if (memRd)       outValid <= 1'b1;
        else if (popOut) outValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mstRst) begin
      aeOff <= bigOffSel ? LARGE_C : SMALL_C;
      afOff <= bigOffSel ? LARGE_C : SMALL_C;
      ldSel <= 1'b0;
    end else if (offLoad) begin
      if (!ldSel) aeOff <= offData;
      else        afOff <= offData;
      ldSel <= ~ldSel;
    end
  end

  always_comb begin
    rdStat      = fwftMode ? outValid : memEmpty;
    wrStat      = fwftMode ? !isFull : isFull;
    halfFull    = (occ > HALF_C);
    almostEmpty = (occ <= CW'(aeOff));
    almostFull  = (freeSpace <= CW'(afOff));
  end
endmodule

// File: rtl/dmfifo_datapath.sv
module dmfifo_datapath
  import dmfifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mstRst,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (stb.memWr && !mstRst) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (mstRst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (stb.memWr) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + AW'(1);
      if (stb.memRd) begin
        rdData <= mem[rdPtr];
        rdPtr  <= (rdPtr == LAST_C) ? '0 : rdPtr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmfifo_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int WIDTH     = 18,
  parameter int OFF_SMALL = 127,
  parameter int OFF_LARGE = 1023,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mstRst,
  input  logic             fwftSel,
  input  logic             bigOffSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdStat,
  output logic             wrStat,
  output logic             halfFull,
  output logic             almostEmpty,
  output logic             almostFull,
  input  logic             offLoad,
  input  logic [OW-1:0]    offData
);
  strobe_t stb;
  logic    fwftMode;

  dmfifo_ctrl #(
    .DEPTH(DEPTH), .OFF_SMALL(OFF_SMALL), .OFF_LARGE(OFF_LARGE)
  ) u_ctrl (
    .clk(clk), .mstRst(mstRst), .fwftSel(fwftSel), .bigOffSel(bigOffSel),
    .wrEn(wrEn), .rdEn(rdEn), .offLoad(offLoad), .offData(offData),
    .stb(stb), .fwftMode(fwftMode), .rdStat(rdStat), .wrStat(wrStat),
    .halfFull(halfFull), .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  dmfifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .mstRst(mstRst), .stb(stb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             mstRst,
  input logic             fwftMode,
  input logic             wrEn,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             rdStat,
  input logic             wrStat,
  input logic             halfFull,
  input logic             almostEmpty,
  input logic             almostFull
);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (mstRst)
    1'b1 |=> $stable(fwftMode));

  // R5
  flag_pair_chk: assert property (@(posedge clk) disable iff (mstRst)
    fwftMode ? (rdStat || wrStat) : !(rdStat && wrStat));

  // R6
  full_flags_chk: assert property (@(posedge clk) disable iff (mstRst)
    (fwftMode ? !wrStat : wrStat) |-> (halfFull && almostFull));

  // R7
  empty_ae_chk: assert property (@(posedge clk) disable iff (mstRst)
    (!fwftMode && rdStat) |-> almostEmpty);

  // R3
  std_hold_chk: assert property (@(posedge clk) disable iff (mstRst)
    (!fwftMode && !(rdEn && !rdStat)) |=> $stable(rdData));

  // R11
  full_ignore_chk: assert property (@(posedge clk) disable iff (mstRst)
    (fwftMode ? (!wrStat && !rdEn) : (wrStat && !rdEn)) |=>
      (fwftMode ? !wrStat : wrStat));

  // R11
  empty_ignore_chk: assert property (@(posedge clk) disable iff (mstRst)
    (!fwftMode && rdStat && !wrEn) |=> (rdStat && $stable(rdData)));
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .mstRst(mstRst), .fwftMode(fwftMode), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .rdStat(rdStat), .wrStat(wrStat), .halfFull(halfFull),
  .almostEmpty(almostEmpty), .almostFull(almostFull)
);

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
  localparam int D  = 16;
  localparam int W  = 8;
  localparam int SM = 3;
  localparam int LG = 5;
  localparam int OW = $clog2(D);

  logic clk = 1'b0;
  logic mstRst = 1'b1, fwftSel = 1'b0, bigOffSel = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, offLoad = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [OW-1:0] offData = '0;
  logic [W-1:0] rdData;
  logic rdStat, wrStat, halfFull, almostEmpty, almostFull;

  always #10 clk = ~clk;

  dual_mode_fifo #(.DEPTH(D), .WIDTH(W), .OFF_SMALL(SM), .OFF_LARGE(LG)) u_dual_mode_fifo (
    .clk(clk), .mstRst(mstRst), .fwftSel(fwftSel), .bigOffSel(bigOffSel),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .rdStat(rdStat), .wrStat(wrStat), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull),
    .offLoad(offLoad), .offData(offData)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] q[$];
  bit mode, ov, haveRd, ldSel;
  logic [W-1:0] outW, lastRd;
  int aeO, afO;
  logic [W-1:0] dcnt = '0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (mode=%0d)", req, act, exp, mode);
    end
  endtask

  task automatic checkAll();
    int occ = q.size() + int'(ov);
    int cap = mode ? D + 1 : D;
    chk("R5 rdStat", int'(rdStat), mode ? int'(ov) : int'(q.size() == 0));
    chk("R5 wrStat", int'(wrStat), mode ? int'(occ != cap) : int'(occ == cap));
    chk("R6 halfFull", int'(halfFull), int'(occ > D / 2));
    chk("R7 almostEmpty", int'(almostEmpty), int'(occ <= aeO));
    chk("R8/R12 almostFull", int'(almostFull), int'(cap - occ <= afO));
    if (mode && ov) chk("R4 fall-through word", int'(rdData), int'(outW));
    if (!mode && haveRd) chk("R3/R1 read word", int'(rdData), int'(lastRd));
  endtask

  task automatic doReset(bit m, bit big);
    @(negedge clk);
    mstRst = 1'b1; fwftSel = m; bigOffSel = big;
    wrEn = 1'b0; rdEn = 1'b0; offLoad = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mstRst = 1'b0;
    fwftSel = !m;     // R2: ignored outside reset
    bigOffSel = !big; // R9: ignored outside reset
    q.delete(); ov = 0; haveRd = 0; ldSel = 0; mode = m;
    aeO = big ? LG : SM; afO = aeO;
    chk("R9 reset almostEmpty", int'(almostEmpty), 1);
    chk("R2 reset rdStat", int'(rdStat), m ? 0 : 1);
    chk("R2 reset wrStat", int'(wrStat), m ? 1 : 0);
    checkAll();
  endtask

  // starts and ends at a falling edge
  task automatic step(bit w, bit r);
    wrEn = w; rdEn = r; wrData = dcnt;
    @(posedge clk);
    begin
      int occ = q.size() + int'(ov);
      int cap = mode ? D + 1 : D;
      bit doW = w && (occ != cap);
      if (!mode) begin
        if (r && q.size() > 0) begin lastRd = q.pop_front(); haveRd = 1; end
      end else begin
        bit pop = r && ov;
        if (q.size() > 0 && (!ov || pop)) begin outW = q.pop_front(); ov = 1; end
        else if (pop) ov = 0;
      end
      if (doW) begin q.push_back(dcnt); dcnt = dcnt + 1'b1; end
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    checkAll();
  endtask

  task automatic loadOff(int v);
    offLoad = 1'b1; offData = OW'(v);
    @(posedge clk);
    if (!ldSel) aeO = v; else afO = v; // R10
    ldSel = !ldSel;
    @(negedge clk);
    offLoad = 1'b0;
    checkAll();
  endtask

  task automatic sweep();
    for (int i = 0; i < D + 3; i++) step(1'b1, 1'b0);  // R1, R11 overfill
    step(1'b1, 1'b0);                                 // R11 write while full
    for (int i = 0; i < D + 4; i++) step(1'b0, 1'b1);  // R3/R4 drain, R11 empty read
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[2], lfsr[1]);
    end
    for (int i = 0; i < D + 3; i++) step(1'b1, 1'b1);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        doReset(m[0], b[0]);
        sweep();
        loadOff(7);  // R10 empty-side first
        loadOff(2);  // R10 full-side second
        loadOff(4);  // R10 wraps to empty-side
        sweep();
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule